// File: doc/BRIEF.md
# PHY Management Serial Master

This block lets a host reach the 16-bit internal registers of an Ethernet PHY over the two-wire management link (clause-22 framing). The host uses a byte-wide register port. It loads a 5-bit register number and then starts a transfer. For a write, the host stores the 16-bit value one byte at a time. For a read, it collects the 16-bit result from a read-back pair. The block divides the system clock to produce the management clock (MDC). It shifts out a 64-bit frame on the data line and samples the PHY's answer. A busy flag covers the whole frame.

A write starts as a side effect of storing the upper byte of the write value. A read starts when the read command bit goes from 0 to 1. That bit stays set after the transfer, and the host clears it. A scan bit repeats reads of the chosen register back to back, and each frame refreshes the read-back pair. Every frame lasts 64 MDC periods, which is 25.6 µs at a 2.5 MHz MDC.

The frame engine has five states:
- IDLE: nothing is in progress.
- PREAMBLE: 32 ones are sent.
- HEADER: start bits, opcode, PHY address and register address are sent.
- TURN: the two turnaround bits.
- DATA: sixteen data bits.

The transitions are:
- IDLE to PREAMBLE on an accepted launch.
- PREAMBLE to HEADER after the last preamble bit.
- HEADER to TURN after the last register-address bit.
- TURN to DATA after the second turnaround bit.
- DATA to IDLE at the end of the frame, or DATA to PREAMBLE when a scan is still requested.

Each move happens on a falling MDC edge.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Host offset 0 stores the register number in bits 4:0, and bits 7:5 read back as 0. Host offset 1 stores a reserved bit in bit 0, which is bit 8 of the address word, and reads it back unchanged with bits 7:1 as 0.
- R2: Writing offset 2 with bit 0 set while bit 0 was clear and the block is idle starts a read, and status bit 0 (offset 3) reads 1 on the next clock. After the read, command bit 0 still reads 1. Writing 1 to it again starts nothing until the host clears it.
- R3: Writing offset 4 (low write byte) starts nothing. Writing offset 5 (high write byte) while idle starts a write of {offset 5, offset 4}, and busy reads 1 on the next clock.
- R4: A single read or write holds busy for exactly 2·HALF_DIV·64 clock cycles, which is 2560 at the defaults.
- R5: MDC is high and low for HALF_DIV clocks each. A write frame shows, on rising MDC edges, MSB first: 32 ones, 01, opcode 01, PHY address, register number, turnaround 10, 16 data bits.
- R6: A read frame carries opcode 10. The master releases the line from the first turnaround bit to the end of the frame, samples on rising MDC, and places the 16 bits, first bit as MSB, in offsets 7 (high) and 6 (low) when busy drops. A PHY that leaves the line pulled up gives 0xFFFF.
- R7: While busy, writes that would set command bit 0 or bit 1, and writes to offsets 4 and 5, have no effect. No extra frame follows.
- R8: Setting command bit 1 while idle starts back-to-back reads of the selected register. Offsets 6/7 refresh after every frame and busy stays 1. Clearing bit 1 ends the scan at the end of the current frame.
- R9: After reset every host register reads 0, MDC is low and the line is released. Whenever idle, MDC is low and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host register offset |
| host_we | input | 1 | Host write strobe, one clock per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at host_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven by the master |
| mdio_oe | output | 1 | Master drives the data line when 1 |
| mdio_i | input | 1 | Resolved data line value |

## Verification
The hardest case to reach is a refresh during an ongoing scan. The register is sampled by the PHY model partway through each frame, so a value changed in the PHY shows up only one full frame later. The stimulus changes the model's register between frames and then waits for two further frame completions before it reads offsets 6/7. Requests made while busy are tested in the middle of both a write and a scan. The stimulus then counts frames on the wire to show that nothing extra was launched.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mgmt_state_e;

    localparam logic [2:0] HOST_ADDR_LO = 3'd0;
    localparam logic [2:0] HOST_ADDR_HI = 3'd1;
    localparam logic [2:0] HOST_CMD     = 3'd2;
    localparam logic [2:0] HOST_STATUS  = 3'd3;
    localparam logic [2:0] HOST_WD_LO   = 3'd4;
    localparam logic [2:0] HOST_WD_HI   = 3'd5;
    localparam logic [2:0] HOST_RD_LO   = 3'd6;
    localparam logic [2:0] HOST_RD_HI   = 3'd7;

    localparam logic [1:0] SOF_BITS = 2'b01;
    localparam logic [1:0] OP_RD    = 2'b10;
    localparam logic [1:0] OP_WR    = 2'b01;
    localparam logic [1:0] TA_DRIVE = 2'b10;
    localparam logic [1:0] TA_FREE  = 2'b11;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic bit_rise,
    output logic bit_fall
);
    localparam int CNT_W = $clog2(HALF_DIV + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap     = run && (cnt_q == CNT_LAST);
    assign bit_rise = wrap && !mdc;
    assign bit_fall = wrap && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int PA_W     = 5,
    parameter int RA_W     = 5,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_write,
    input  logic              scan_en,
    input  logic [PA_W-1:0]   phy_addr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit_rise,
    input  logic              bit_fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_word
);
    localparam int FRAME_BITS = PRE_BITS + 6 + PA_W + RA_W + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_FIRST   = PRE_BITS + 4 + PA_W + RA_W;
    localparam int DATA_FIRST = TA_FIRST + 2;
    localparam logic [IDX_W-1:0] PRE_LAST  = IDX_W'(PRE_BITS - 1);
    localparam logic [IDX_W-1:0] HDR_LAST  = IDX_W'(TA_FIRST - 1);
    localparam logic [IDX_W-1:0] TURN_LAST = IDX_W'(DATA_FIRST - 1);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic              wr,
        input logic [PA_W-1:0]   pa,
        input logic [RA_W-1:0]   ra,
        input logic [DATA_W-1:0] d
    );
        return {{PRE_BITS{1'b1}}, SOF_BITS, (wr ? OP_WR : OP_RD), pa, ra,
                (wr ? TA_DRIVE : TA_FREE), (wr ? d : {DATA_W{1'b1}})};
    endfunction

    mgmt_state_e             state_q, state_d;
    logic [IDX_W-1:0]        idx_q;
    logic [FRAME_BITS-1:0]   sr_q;
    logic                    wr_q;
    logic [PA_W-1:0]         pa_q;
    logic [RA_W-1:0]         ra_q;
    logic [DATA_W-1:0]       rx_q;
    logic                    frame_end;
    logic                    again;

    assign frame_end = bit_fall && (idx_q == LAST_IDX);
    assign again     = scan_en && !wr_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (bit_fall && idx_q == PRE_LAST) state_d = ST_HEADER;
            ST_HEADER:   if (bit_fall && idx_q == HDR_LAST) state_d = ST_TURN;
            ST_TURN:     if (bit_fall && idx_q == TURN_LAST) state_d = ST_DATA;
            ST_DATA:     if (frame_end) state_d = again ? ST_PREAMBLE : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            sr_q  <= '0;
            wr_q  <= 1'b0;
            pa_q  <= '0;
            ra_q  <= '0;
            rx_q  <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                sr_q  <= build_frame(start_write, phy_addr, reg_addr, wr_data);
                idx_q <= '0;
                wr_q  <= start_write;
                pa_q  <= phy_addr;
                ra_q  <= reg_addr;
            end
        end else begin
            if (bit_rise && state_q == ST_DATA && !wr_q)
                rx_q <= {rx_q[DATA_W-2:0], mdio_i};
            if (frame_end) begin
                idx_q <= '0;
                if (again) sr_q <= build_frame(1'b0, pa_q, ra_q, '0);
            end else if (bit_fall) begin
                idx_q <= idx_q + 1'b1;
                sr_q  <= {sr_q[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        busy    = 1'b1;
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:                busy = 1'b0;
            ST_PREAMBLE, ST_HEADER: mdio_oe = 1'b1;
            ST_TURN, ST_DATA:       mdio_oe = wr_q;
            default:                busy = 1'b0;
        endcase
        mdio_o  = sr_q[FRAME_BITS-1];
        rd_done = (state_q == ST_DATA) && frame_end && !wr_q;
        rd_word = rx_q;
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int HALF_DIV = 20,
    parameter int PHY_ADDR = 1,
    parameter int PRE_BITS = 32,
    parameter int HOST_W   = 8,
    parameter int PA_W     = 5,
    parameter int RA_W     = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] host_addr,
    input  logic       host_we,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       mdc,
    output logic       mdio_o,
    output logic       mdio_oe,
    input  logic       mdio_i
);
    localparam int DATA_W     = 2 * HOST_W;
    localparam int FRAME_BITS = PRE_BITS + 6 + PA_W + RA_W + DATA_W;

    logic [RA_W-1:0]   ra_q;
    logic              rsv_q;
    logic              cmd_rd;
    logic              cmd_scan;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rd_q;
    logic              busy;
    logic              start_rd, start_wr;
    logic              bit_rise, bit_fall;
    logic              rd_done;
    logic [DATA_W-1:0] rd_word;
    logic [HOST_W-1:0] wd_hi;

    assign wd_hi    = wd_q[DATA_W-1:HOST_W];
    assign start_rd = host_we && !busy && (host_addr == HOST_CMD) &&
                      ((host_wdata[0] && !cmd_rd) || (host_wdata[1] && !cmd_scan));
    assign start_wr = host_we && !busy && (host_addr == HOST_WD_HI);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_q     <= '0;
            rsv_q    <= 1'b0;
            cmd_rd   <= 1'b0;
            cmd_scan <= 1'b0;
            wd_q     <= '0;
            rd_q     <= '0;
        end else begin
            if (host_we) begin
                case (host_addr)
                    HOST_ADDR_LO: ra_q  <= host_wdata[RA_W-1:0];
                    HOST_ADDR_HI: rsv_q <= host_wdata[0];
                    HOST_CMD: begin
                        cmd_rd   <= host_wdata[0] && (cmd_rd || !busy);
                        cmd_scan <= host_wdata[1] && (cmd_scan || !busy);
                    end
                    HOST_WD_LO: if (!busy) wd_q[HOST_W-1:0] <= host_wdata;
                    HOST_WD_HI: if (!busy) wd_q[DATA_W-1:HOST_W] <= host_wdata;
                    default: ;
                endcase
            end
            if (rd_done) rd_q <= rd_word;
        end
    end

    always_comb begin
        case (host_addr)
            HOST_ADDR_LO: host_rdata = HOST_W'(ra_q);
            HOST_ADDR_HI: host_rdata = {{(HOST_W-1){1'b0}}, rsv_q};
            HOST_CMD:     host_rdata = {{(HOST_W-2){1'b0}}, cmd_scan, cmd_rd};
            HOST_STATUS:  host_rdata = {{(HOST_W-1){1'b0}}, busy};
            HOST_WD_LO:   host_rdata = wd_q[HOST_W-1:0];
            HOST_WD_HI:   host_rdata = wd_hi;
            HOST_RD_LO:   host_rdata = rd_q[HOST_W-1:0];
            default:      host_rdata = rd_q[DATA_W-1:HOST_W];
        endcase
    end

    mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .bit_rise (bit_rise),
        .bit_fall (bit_fall)
    );

    mdio_frame_engine #(
        .PRE_BITS (PRE_BITS),
        .PA_W     (PA_W),
        .RA_W     (RA_W),
        .DATA_W   (DATA_W)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_rd || start_wr),
        .start_write (start_wr),
        .scan_en     (cmd_scan),
        .phy_addr    (PA_W'(PHY_ADDR)),
        .reg_addr    (ra_q),
        .wr_data     ({host_wdata, wd_q[HOST_W-1:0]}),
        .bit_rise    (bit_rise),
        .bit_fall    (bit_fall),
        .mdio_i      (mdio_i),
        .busy        (busy),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .rd_done     (rd_done),
        .rd_word     (rd_word)
    );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
    import mdio_mgmt_pkg::*;
#(
    parameter int FRAME_CYC = 2560,
    parameter int HOST_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        addr,
    input logic              we,
    input logic              cmd_bit,
    input logic              busy,
    input logic              cmd_rd,
    input logic              mdc,
    input logic              mdio_oe,
    input logic [HOST_W-1:0] wd_hi
);
    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= '0;
    end

    // R2
    read_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && we && addr == HOST_CMD && cmd_bit && !cmd_rd) |=> busy);

    // R3
    write_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && we && addr == HOST_WD_HI) |=> busy);

    // R4
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q != 0 && (run_q % FRAME_CYC) == 0));

    // R7
    busy_cmd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && we && addr == HOST_CMD && !cmd_rd) |=> !cmd_rd);

    // R7
    busy_wd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && we && addr == HOST_WD_HI) |=> (wd_hi == $past(wd_hi)));

    // R9
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));
endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(
    .FRAME_CYC (2 * HALF_DIV * FRAME_BITS),
    .HOST_W    (HOST_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (host_addr),
    .we      (host_we),
    .cmd_bit (host_wdata[0]),
    .busy    (busy),
    .cmd_rd  (cmd_rd),
    .mdc     (mdc),
    .mdio_oe (mdio_oe),
    .wd_hi   (wd_hi)
);

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
    import mdio_mgmt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 20;
    localparam int PHY        = 1;
    localparam int FRAME_CYC  = 2 * HALF * 64;
    localparam logic [31:0] IMPL_MASK = 32'h8802_0073;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic       host_we = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       mdc, mdio_o, mdio_oe, mdio_line;
    logic       phy_oe = 1'b0;
    logic       phy_o = 1'b1;

    int nchk = 0;
    int nerr = 0;
    int frames = 0;
    bit done = 1'b0;

    logic [15:0] bank [32];
    logic [63:0] wire_bits = '0;
    logic [4:0]  last_pa = '0;

    logic [15:0] exp_q[$];
    string       exp_tag[$];
    logic [15:0] obs_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    mdio_mgmt_master #(.HALF_DIV(HALF), .PHY_ADDR(PHY)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .mdio_i     (mdio_line)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // wire capture on rising MDC
    always @(posedge mdc) wire_bits <= {wire_bits[62:0], mdio_line};

    // behavioural PHY register bank
    initial begin : phy_model
        logic [33:0] hist;
        logic [11:0] hdr;
        logic [17:0] wd;
        logic [15:0] rv;
        hist = '0;
        hdr  = '0;
        wd   = '0;
        for (int i = 0; i < 32; i++) bank[i] = 16'h0;
        forever begin
            @(posedge mdc);
            hist = {hist[32:0], mdio_line};
            if (hist == {32'hFFFF_FFFF, 2'b01}) begin
                for (int i = 0; i < 12; i++) begin
                    @(posedge mdc);
                    hdr = {hdr[10:0], mdio_line};
                end
                last_pa = hdr[9:5];
                if (hdr[11:10] == 2'b10) begin
                    rv = IMPL_MASK[hdr[4:0]] ? bank[hdr[4:0]] : 16'hFFFF;
                    @(negedge mdc);
                    @(negedge mdc);
                    #1;
                    check("R6 master releases line in turnaround", 64'(mdio_oe), 64'd0);
                    phy_oe = 1'b1;
                    phy_o  = 1'b0;
                    for (int i = 0; i < 16; i++) begin
                        @(negedge mdc);
                        phy_o = rv[15-i];
                    end
                    @(negedge mdc);
                    phy_oe = 1'b0;
                end else begin
                    for (int i = 0; i < 18; i++) begin
                        @(posedge mdc);
                        wd = {wd[16:0], mdio_line};
                    end
                    if (IMPL_MASK[hdr[4:0]]) bank[hdr[4:0]] = wd[15:0];
                end
                frames++;
                hist = '0;
            end
        end
    end

    // scoreboard monitor
    initial begin : monitor
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                logic [15:0] o, e;
                string t;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                t = exp_tag.pop_front();
                check(t, 64'(o), 64'(e));
            end
        end
    end

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        host_addr = HOST_STATUS;
        #1;
        while (host_rdata[0] && n < 20000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic collect_rdata();
        logic [7:0] lo, hi;
        host_read(HOST_RD_LO, lo);
        host_read(HOST_RD_HI, hi);
        obs_q.push_back({hi, lo});
    endtask

    task automatic read_op(input logic [4:0] ra, input logic [15:0] expv, input string tag);
        int n;
        host_write(HOST_ADDR_LO, {3'b000, ra});
        host_write(HOST_CMD, 8'h01);
        wait_idle(n);
        exp_q.push_back(expv);
        exp_tag.push_back(tag);
        collect_rdata();
        host_write(HOST_CMD, 8'h00);
    endtask

    task automatic wait_frames(input int k);
        int target;
        target = frames + k;
        while (frames < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin : driver
        logic [7:0] b;
        int n, f0;
        time t0;

        repeat (5) @(negedge clk);
        host_read(HOST_STATUS, b);   check("R9 status after reset", 64'(b), 64'h0);
        host_read(HOST_RD_LO, b);    check("R9 rdata low after reset", 64'(b), 64'h0);
        host_read(HOST_ADDR_HI, b);  check("R9 reserved bit after reset", 64'(b), 64'h0);
        check("R9 line released in reset", 64'({mdc, mdio_oe}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 address register and reserved bit
        host_write(HOST_ADDR_LO, 8'hE4);
        host_read(HOST_ADDR_LO, b);  check("R1 register field", 64'(b), 64'h04);
        host_write(HOST_ADDR_HI, 8'hFF);
        host_read(HOST_ADDR_HI, b);  check("R1 reserved bit kept", 64'(b), 64'h01);

        // R3 / R4 / R5 write
        host_write(HOST_WD_LO, 8'hC3);
        host_read(HOST_STATUS, b);   check("R3 low byte starts nothing", 64'(b), 64'h0);
        host_write(HOST_WD_HI, 8'hA5);
        host_addr = HOST_STATUS; #1;
        check("R3 busy after high byte", 64'(host_rdata[0]), 64'h1);
        wait_idle(n);
        check("R4 write busy length", 64'(n), 64'(FRAME_CYC));
        check("R5 write frame on wire", wire_bits,
              {32'hFFFF_FFFF, 2'b01, 2'b01, 5'(PHY), 5'd4, 2'b10, 16'hA5C3});
        check("R5 PHY address field", 64'(last_pa), 64'(PHY));

        // R2 / R6 read, MDC half period
        host_write(HOST_CMD, 8'h01);
        @(posedge mdc); t0 = $time;
        @(negedge mdc);
        check("R5 MDC high time", 64'($time - t0), 64'(HALF * CLK_PERIOD));
        wait_idle(n);
        host_read(HOST_CMD, b);      check("R2 read bit stays set", 64'(b), 64'h01);
        exp_q.push_back(16'hA5C3); exp_tag.push_back("R6 read back written value");
        collect_rdata();
        f0 = frames;
        host_write(HOST_CMD, 8'h01);
        host_read(HOST_STATUS, b);   check("R2 no relaunch while bit held", 64'(b), 64'h0);
        host_write(HOST_CMD, 8'h00);
        check("R2 no extra frame", 64'(frames), 64'(f0));

        // R6 unimplemented read, write ignored by PHY
        read_op(5'd2, 16'hFFFF, "R6 pulled-up line gives FFFF");
        host_write(HOST_ADDR_LO, 8'h03);
        host_write(HOST_WD_LO, 8'h34);
        host_write(HOST_WD_HI, 8'h12);
        wait_idle(n);
        read_op(5'd3, 16'hFFFF, "R6 unimplemented stays FFFF");

        // R7 requests while busy
        host_write(HOST_ADDR_LO, 8'h11);
        host_write(HOST_WD_LO, 8'h5A);
        host_write(HOST_WD_HI, 8'h0F);
        f0 = frames;
        host_write(HOST_CMD, 8'h03);
        host_read(HOST_CMD, b);      check("R7 command set ignored while busy", 64'(b), 64'h0);
        host_write(HOST_WD_HI, 8'hEE);
        host_read(HOST_WD_HI, b);    check("R7 high byte ignored while busy", 64'(b), 64'h0F);
        host_write(HOST_WD_LO, 8'h77);
        host_read(HOST_WD_LO, b);    check("R7 low byte ignored while busy", 64'(b), 64'h5A);
        wait_idle(n);
        repeat (200) @(negedge clk);
        host_read(HOST_STATUS, b);   check("R7 no extra launch", 64'(b), 64'h0);
        check("R7 one frame only", 64'(frames - f0), 64'd1);
        read_op(5'd17, 16'h0F5A, "R7 intact write data reached PHY");

        // R8 scan
        bank[5] = 16'h1111;
        host_write(HOST_ADDR_LO, 8'h05);
        host_write(HOST_CMD, 8'h02);
        wait_frames(1);
        exp_q.push_back(16'h1111); exp_tag.push_back("R8 scan first value");
        collect_rdata();
        bank[5] = 16'h2222;
        wait_frames(2);
        exp_q.push_back(16'h2222); exp_tag.push_back("R8 scan refreshed value");
        collect_rdata();
        host_read(HOST_STATUS, b);   check("R8 busy held during scan", 64'(b), 64'h1);
        host_write(HOST_CMD, 8'h03);
        host_read(HOST_CMD, b);      check("R7 read bit ignored during scan", 64'(b), 64'h02);
        host_write(HOST_CMD, 8'h00);
        wait_idle(n);
        check("R8 scan stops within one frame", 64'(n <= FRAME_CYC), 64'h1);
        f0 = frames;
        repeat (FRAME_CYC + 100) @(negedge clk);
        check("R8 no frames after scan cleared", 64'(frames), 64'(f0));

        repeat (5) @(negedge clk);
        check("scoreboard drained", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule